// File: doc/BRIEF.md
# Link Speed Policy Controller (2.5 / 5.0 GT/s)

This block decides, for one switch port running at either 2.5 GT/s or 5.0 GT/s, when the link should change speed and which rates the port offers in the training sets it sends. It does not run the link training state machine. Training milestones arrive as one-cycle strobes: the partner's entry into Configuration.Complete or Recovery.RcvrCfg, a partner speed-change request, and the end of a speed change with its outcome. The block answers by pulsing a request to enter Recovery and by holding a speed-change flag for the length of the change.

There are three ways to start a change. Software writes a target speed and then writes a retrain pulse. The PHY reports that 5.0 GT/s is unreliable. The partner asks for a rate. The policy is not symmetric. A software downgrade withdraws 5.0 GT/s from the advertised rates, but a reliability downgrade keeps offering it. A failed upgrade falls back to 2.5 GT/s and is never retried by the block on its own. When the port is on the downstream side, a partner's autonomous speed change is recorded in a status bit that software clears, and this status bit can raise an interrupt.

Top module: `link_rate_policy`

## Requirements
- R1: After reset the target speed is 5.0 GT/s (code 2), the current speed is 2.5 GT/s (code 1), advertised rates are 2'b11 (bit 0 = 2.5 GT/s, bit 1 = 5.0 GT/s), and speedChangeReq, recoveryReq, autoBwSts and bwIrq are 0.
- R2: A retrain pulse while no change is outstanding gives a one-cycle recoveryReq on the next edge. speedChangeReq is set there if the target differs from the current speed and is allowed. When evChangeDone arrives with changeOk=1, the current speed takes the requested speed and speedChangeReq clears.
- R3: An upgrade to 5.0 GT/s is requested only if the 5.0 GT/s capability the partner showed at its most recent Configuration.Complete or Recovery.RcvrCfg strobe was set. Otherwise Recovery is entered with speedChangeReq=0 and the speed stays the same.
- R4: phyFault at 5.0 GT/s requests a change to 2.5 GT/s and leaves advertised rates at 2'b11. phyFault at 2.5 GT/s has no effect.
- R5: A retrain with target 2.5 GT/s sets advertised rates to 2'b01. A retrain with target 5.0 GT/s restores 2'b11.
- R6: evChangeDone with changeOk=0 sets the current speed to 2.5 GT/s. The block then raises no recoveryReq until software or the partner starts a change.
- R7: A partner request is always answered with recoveryReq. speedChangeReq is 1 only when both sides offer the requested rate and it differs from the current speed.
- R8: autoChgBit, the autonomous-change bit for outgoing training sets, is always 0.
- R9: hasdRd is always 0. A target write with a code other than 1 or 2 leaves the target unchanged.
- R10: In the downstream variant, a successful partner change flagged autonomous sets autoBwSts. stsClrWr clears it, and a set wins over a clear in the same cycle. bwIrq equals autoBwSts AND the interrupt enable.
- R11: While a change is outstanding, new retrain, fault or partner strobes produce no recoveryReq. When several arrive in the same idle cycle, the priority is partner, then fault, then retrain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| tlsWrEn | input | 1 | Target speed write strobe |
| tlsWrData | input | 2 | Target speed code (1 or 2) |
| retrainWr | input | 1 | Software retrain pulse |
| intEnWrEn | input | 1 | Interrupt enable write strobe |
| intEnWrData | input | 1 | Interrupt enable value |
| stsClrWr | input | 1 | Write-1-to-clear for autoBwSts |
| partnerGen2 | input | 1 | Partner currently offers 5.0 GT/s |
| evCfgComplete | input | 1 | Partner entered Configuration.Complete |
| evRcvrCfg | input | 1 | Partner entered Recovery.RcvrCfg |
| phyFault | input | 1 | PHY reports unreliable high-rate operation |
| evPartnerReq | input | 1 | Partner speed-change request |
| partnerReqSpd | input | 2 | Speed code the partner requests |
| partnerAutoChg | input | 1 | Partner flags its request autonomous |
| evChangeDone | input | 1 | Speed change finished |
| changeOk | input | 1 | Outcome of the finished change |
| advRates | output | 2 | Rates advertised in training sets |
| speedChangeReq | output | 1 | Speed-change flag during a change |
| recoveryReq | output | 1 | One-cycle request to enter Recovery |
| autoChgBit | output | 1 | Autonomous-change bit sent |
| curSpd | output | 2 | Current speed code |
| targetSpd | output | 2 | Target speed code |
| hasdRd | output | 1 | Autonomous speed disable read value |
| autoBwSts | output | 1 | Autonomous bandwidth status |
| bwIrq | output | 1 | Bandwidth interrupt |

## Verification
The bench builds the block with its default DOWNSTREAM=1. This brings the autonomous-bandwidth status path within reach: setting it, clearing it, clear racing with set, and the interrupt enable mask. The upstream variant ties the status low and is not built by the bench. Within that build the bench walks the block through every kind of change: software upgrade and downgrade, retrain to the same speed, an upgrade the partner cannot support, a reliability fault at each speed, a failed upgrade followed by an idle wait, and partner requests with and without rate support.

// File: rtl/lrp_pkg.sv
package lrp_pkg;
  localparam int SPD_W = 2;
  typedef logic [SPD_W-1:0] spd_t;
  localparam spd_t SPD_GEN1 = 2'd1;
  localparam spd_t SPD_GEN2 = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic takeRetrain;
    logic commit;
    spd_t commitSpd;
    logic setAutoBw;
  } ctlStb_t;
endpackage

// File: rtl/lrp_ctrl.sv
module lrp_ctrl
  import lrp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    retrainWr,
  input  logic    phyFault,
  input  logic    evPartnerReq,
  input  spd_t    partnerReqSpd,
  input  logic    partnerAutoChg,
  input  logic    evChangeDone,
  input  logic    changeOk,
  input  spd_t    targetSpd,
  input  spd_t    curSpd,
  input  logic    partnerGen2Lat,
  input  logic    adv5,
  output ctlStb_t stb,
  output logic    speedChangeReq,
  output logic    recoveryReq
);
  logic busy;
  spd_t pendSpd;
  logic pendAuto;

  logic supported, partnerChg, faultHit, upOk, swChg, doneHit;

  always_comb begin
    supported  = (partnerReqSpd == SPD_GEN1) ||
                 ((partnerReqSpd == SPD_GEN2) && adv5 && partnerGen2Lat);
    partnerChg = supported && (partnerReqSpd != curSpd);
    faultHit   = phyFault && (curSpd == SPD_GEN2);
    upOk       = (targetSpd == SPD_GEN2) ? partnerGen2Lat : 1'b1;
    swChg      = (targetSpd != curSpd) && upOk;
    doneHit    = busy && evChangeDone;
    stb.takeRetrain = !busy && retrainWr && !evPartnerReq && !faultHit;
    stb.commit      = doneHit;
    stb.commitSpd   = changeOk ? pendSpd : SPD_GEN1;
    stb.setAutoBw   = doneHit && changeOk && pendAuto;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy           <= 1'b0;
      pendSpd        <= SPD_GEN1;
      pendAuto       <= 1'b0;
      speedChangeReq <= 1'b0;
      recoveryReq    <= 1'b0;
    end else begin
      recoveryReq <= 1'b0;
      if (!busy) begin
        if (evPartnerReq) begin
          busy           <= 1'b1;
          recoveryReq    <= 1'b1;
          speedChangeReq <= partnerChg;
          pendSpd        <= partnerChg ? partnerReqSpd : curSpd;
          pendAuto       <= partnerChg && partnerAutoChg;
        end else if (faultHit) begin
          busy           <= 1'b1;
          recoveryReq    <= 1'b1;
          speedChangeReq <= 1'b1;
          pendSpd        <= SPD_GEN1;
          pendAuto       <= 1'b0;
        end else if (retrainWr) begin
          busy           <= 1'b1;
          recoveryReq    <= 1'b1;
          speedChangeReq <= swChg;
          pendSpd        <= swChg ? targetSpd : curSpd;
          pendAuto       <= 1'b0;
        end
      end else if (evChangeDone) begin
        busy           <= 1'b0;
        speedChangeReq <= 1'b0;
      end
    end
  end

  // R11: Recovery is only requested from idle
  a_r11_idle_start: assert property (@(posedge clk) disable iff (!rstN)
    recoveryReq |-> !$past(busy));
  // R2: the Recovery request lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    recoveryReq |=> !recoveryReq);
  // R3: a raised upgrade request implies the partner showed 5.0 GT/s
  a_r3_up_needs_partner: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(speedChangeReq) && pendSpd == SPD_GEN2) |-> $past(partnerGen2Lat));
  // R6: a failed change lands on 2.5 GT/s
  a_r6_fail_fallback: assert property (@(posedge clk) disable iff (!rstN)
    (busy && evChangeDone && !changeOk) |=> curSpd == SPD_GEN1);
endmodule

// File: rtl/lrp_dp.sv
module lrp_dp
  import lrp_pkg::*;
#(
  parameter bit DOWNSTREAM = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tlsWrEn,
  input  spd_t    tlsWrData,
  input  logic    intEnWrEn,
  input  logic    intEnWrData,
  input  logic    stsClrWr,
  input  logic    evCfgComplete,
  input  logic    evRcvrCfg,
  input  logic    partnerGen2,
  input  ctlStb_t stb,
  output spd_t    targetSpd,
  output spd_t    curSpd,
  output logic    adv5,
  output logic    partnerGen2Lat,
  output logic    autoBwSts,
  output logic    bwIrq
);
  logic intEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetSpd      <= SPD_GEN2;
      curSpd         <= SPD_GEN1;
      adv5           <= 1'b1;
      partnerGen2Lat <= 1'b0;
      intEn          <= 1'b0;
    end else begin
      if (tlsWrEn && (tlsWrData == SPD_GEN1 || tlsWrData == SPD_GEN2))
        targetSpd <= tlsWrData;
      if (stb.commit)
        curSpd <= stb.commitSpd;
      if (stb.takeRetrain)
        adv5 <= (targetSpd == SPD_GEN2);
      if (evCfgComplete || evRcvrCfg)
        partnerGen2Lat <= partnerGen2;
      if (intEnWrEn)
        intEn <= intEnWrData;
    end
  end

  generate
    if (DOWNSTREAM) begin : g_dsp
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              autoBwSts <= 1'b0;
        else if (stb.setAutoBw) autoBwSts <= 1'b1;
        else if (stsClrWr)      autoBwSts <= 1'b0;
      end
    end else begin : g_usp
      assign autoBwSts = 1'b0;
    end
  endgenerate

  assign bwIrq = autoBwSts && intEn;

  // R4: advertised rates move only on an accepted software retrain
  a_r4_adv_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.takeRetrain) |-> $stable(adv5));
  // R10: status rises only after a successful autonomous partner change
  a_r10_sts_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(autoBwSts) |-> $past(stb.setAutoBw));
endmodule

// File: rtl/link_rate_policy.sv
module link_rate_policy
  import lrp_pkg::*;
#(
  parameter bit DOWNSTREAM = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tlsWrEn,
  input  logic [1:0] tlsWrData,
  input  logic       retrainWr,
  input  logic       intEnWrEn,
  input  logic       intEnWrData,
  input  logic       stsClrWr,
  input  logic       partnerGen2,
  input  logic       evCfgComplete,
  input  logic       evRcvrCfg,
  input  logic       phyFault,
  input  logic       evPartnerReq,
  input  logic [1:0] partnerReqSpd,
  input  logic       partnerAutoChg,
  input  logic       evChangeDone,
  input  logic       changeOk,
  output logic [1:0] advRates,
  output logic       speedChangeReq,
  output logic       recoveryReq,
  output logic       autoChgBit,
  output logic [1:0] curSpd,
  output logic [1:0] targetSpd,
  output logic       hasdRd,
  output logic       autoBwSts,
  output logic       bwIrq
);
  ctlStb_t stb;
  logic    adv5;
  logic    partnerGen2Lat;

  lrp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .retrainWr(retrainWr), .phyFault(phyFault),
    .evPartnerReq(evPartnerReq), .partnerReqSpd(partnerReqSpd),
    .partnerAutoChg(partnerAutoChg), .evChangeDone(evChangeDone),
    .changeOk(changeOk), .targetSpd(targetSpd), .curSpd(curSpd),
    .partnerGen2Lat(partnerGen2Lat), .adv5(adv5), .stb(stb),
    .speedChangeReq(speedChangeReq), .recoveryReq(recoveryReq)
  );

  lrp_dp #(.DOWNSTREAM(DOWNSTREAM)) i_dp (
    .clk(clk), .rstN(rstN), .tlsWrEn(tlsWrEn), .tlsWrData(tlsWrData),
    .intEnWrEn(intEnWrEn), .intEnWrData(intEnWrData), .stsClrWr(stsClrWr),
    .evCfgComplete(evCfgComplete), .evRcvrCfg(evRcvrCfg),
    .partnerGen2(partnerGen2), .stb(stb), .targetSpd(targetSpd),
    .curSpd(curSpd), .adv5(adv5), .partnerGen2Lat(partnerGen2Lat),
    .autoBwSts(autoBwSts), .bwIrq(bwIrq)
  );

  assign advRates   = {adv5, 1'b1};
  assign autoChgBit = 1'b0;
  assign hasdRd     = 1'b0;
endmodule

// File: tb/test_link_rate_policy.sv
module test_link_rate_policy;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tlsWrEn = 0, retrainWr = 0, intEnWrEn = 0, intEnWrData = 0, stsClrWr = 0;
  logic [1:0] tlsWrData = 2'd0, partnerReqSpd = 2'd0;
  logic partnerGen2 = 0, evCfgComplete = 0, evRcvrCfg = 0, phyFault = 0;
  logic evPartnerReq = 0, partnerAutoChg = 0, evChangeDone = 0, changeOk = 0;
  logic [1:0] advRates, curSpd, targetSpd;
  logic speedChangeReq, recoveryReq, autoChgBit, hasdRd, autoBwSts, bwIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_rate_policy i_link_rate_policy (.*);

  typedef struct {
    string      req;
    logic [1:0] adv;
    logic       scr;
    logic       rec;
    logic [1:0] cur;
    logic [1:0] tgt;
    logic       sts;
    logic       irq;
  } exp_t;

  exp_t q[$];
  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  // expected model state
  logic [1:0] eAdv = 2'b11, eCur = 2'd1, eTgt = 2'd2;
  logic eScr = 0, eSts = 0, eIrq = 0;

  task automatic tick();
    @(posedge clk);
    #1;
    tlsWrEn = 0; retrainWr = 0; intEnWrEn = 0; stsClrWr = 0;
    evCfgComplete = 0; evRcvrCfg = 0; phyFault = 0; evPartnerReq = 0;
    evChangeDone = 0; partnerAutoChg = 0;
  endtask

  task automatic expect_now(string req, logic rec);
    exp_t e;
    e.req = req; e.adv = eAdv; e.scr = eScr; e.rec = rec; e.cur = eCur;
    e.tgt = eTgt; e.sts = eSts; e.irq = eIrq;
    q.push_back(e);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      testCnt++;
      if ({advRates, speedChangeReq, recoveryReq, curSpd, targetSpd, autoBwSts, bwIrq}
          !== {e.adv, e.scr, e.rec, e.cur, e.tgt, e.sts, e.irq}) begin
        failCnt++;
        $display("FAIL %s adv=%b scr=%b rec=%b cur=%0d tgt=%0d sts=%b irq=%b | exp adv=%b scr=%b rec=%b cur=%0d tgt=%0d sts=%b irq=%b",
                 e.req, advRates, speedChangeReq, recoveryReq, curSpd, targetSpd, autoBwSts, bwIrq,
                 e.adv, e.scr, e.rec, e.cur, e.tgt, e.sts, e.irq);
      end
      testCnt++;
      if (autoChgBit !== 1'b0 || hasdRd !== 1'b0) begin
        failCnt++;
        $display("FAIL R8/R9 autoChgBit=%b hasdRd=%b exp 0 0", autoChgBit, hasdRd);
      end
    end
  end

  task automatic done(logic ok);
    evChangeDone = 1; changeOk = ok; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    expect_now("R1 reset", 0);
    tick(); expect_now("R1 reset hold", 0);

    // R3: partner has not shown 5.0 GT/s
    retrainWr = 1; tick(); expect_now("R3 retrain no partner gen2", 1);
    tick(); expect_now("R3 pulse ends", 0);
    done(1); expect_now("R3 speed kept", 0);

    // latch partner capability
    partnerGen2 = 1; evRcvrCfg = 1; tick(); expect_now("R3 latch", 0);

    // R2: upgrade
    retrainWr = 1; tick(); eScr = 1; expect_now("R2 upgrade start", 1);
    done(1); eScr = 0; eCur = 2; expect_now("R2 upgrade done", 0);

    // R2: retrain at same speed
    retrainWr = 1; tick(); expect_now("R2 same speed retrain", 1);
    done(1); expect_now("R2 same speed done", 0);

    // R4: fault at 5.0
    phyFault = 1; tick(); eScr = 1; expect_now("R4 fault downgrade", 1);
    done(1); eScr = 0; eCur = 1; expect_now("R4 fault keeps adv", 0);
    phyFault = 1; tick(); expect_now("R4 fault at gen1 ignored", 0);

    // R9: illegal target code ignored
    tlsWrEn = 1; tlsWrData = 2'd3; tick(); expect_now("R9 bad target code", 0);

    // R5: back to 5.0 then software downgrade
    retrainWr = 1; tick(); eScr = 1; expect_now("R5 re-upgrade", 1);
    done(1); eScr = 0; eCur = 2; expect_now("R5 re-upgrade done", 0);
    tlsWrEn = 1; tlsWrData = 2'd1; tick(); eTgt = 1; expect_now("R5 target gen1", 0);
    retrainWr = 1; tick(); eScr = 1; eAdv = 2'b01; expect_now("R5 sw downgrade drops adv", 1);
    done(1); eScr = 0; eCur = 1; expect_now("R5 sw downgrade done", 0);

    // R7: partner asks 5.0 while port does not offer it
    evPartnerReq = 1; partnerReqSpd = 2'd2; tick(); expect_now("R7 unsupported partner req", 1);
    done(1); expect_now("R7 speed kept", 0);

    // R6: failed upgrade
    tlsWrEn = 1; tlsWrData = 2'd2; tick(); eTgt = 2; expect_now("R6 target gen2", 0);
    retrainWr = 1; tick(); eScr = 1; eAdv = 2'b11; expect_now("R6 upgrade start", 1);
    done(0); eScr = 0; eCur = 1; expect_now("R6 fail fallback", 0);
    for (int i = 0; i < 20; i++) begin
      tick(); expect_now("R6 no autonomous retry", 0);
    end

    // R7/R10: partner autonomous upgrade, R11 busy ignores retrain
    evPartnerReq = 1; partnerReqSpd = 2'd2; partnerAutoChg = 1; tick();
    eScr = 1; expect_now("R7 supported partner req", 1);
    retrainWr = 1; phyFault = 1; tick(); expect_now("R11 busy ignores strobes", 0);
    done(1); eScr = 0; eCur = 2; eSts = 1; expect_now("R10 status set", 0);
    intEnWrEn = 1; intEnWrData = 1; tick(); eIrq = 1; expect_now("R10 irq on enable", 0);
    stsClrWr = 1; tick(); eSts = 0; eIrq = 0; expect_now("R10 w1c clear", 0);

    // R10: set wins over clear; R11 priority partner over fault
    evPartnerReq = 1; partnerReqSpd = 2'd1; partnerAutoChg = 1; phyFault = 1; tick();
    eScr = 1; expect_now("R11 partner beats fault", 1);
    evChangeDone = 1; changeOk = 1; stsClrWr = 1; tick();
    eScr = 0; eCur = 1; eSts = 1; eIrq = 1; expect_now("R10 set beats clear", 0);
    stsClrWr = 1; tick(); eSts = 0; eIrq = 0; expect_now("R10 cleared", 0);

    // R3: Configuration.Complete relatch without 5.0
    partnerGen2 = 0; evCfgComplete = 1; tick(); expect_now("R3 cfg relatch", 0);
    retrainWr = 1; tick(); expect_now("R3 upgrade withheld", 1);
    done(1); expect_now("R3 stays gen1", 0);

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule